// File: doc/BRIEF.md
# Ownership-Aware Victim Selector

This block picks the way to evict when a miss lands in one set of a set-associative last-level cache shared by several cores. Each way carries a small owner field naming the core that holds it. Each core has one flag saying it already holds more than its share of the cache. The block gets the requesting core, the set's valid bits, owner fields and per-way LRU ages, plus the flags of every core. One cycle later it returns the chosen way and the owner value to write into it.

A core whose flag is clear uses plain LRU replacement. A core whose flag is set may only replace a line it already owns, and it picks one of those lines at random. Lines held by other cores are then left alone, and over time the cores that are under their share take space from it. If a flagged core owns nothing in the set, it still gets a line through LRU. An empty (invalid) way is always filled first, whatever the flags say.

Top module: `victim_picker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `vic_valid` is 0.
- R2: A request sampled on a rising edge while `req_valid` is 1 makes `vic_valid` 1 for exactly the following cycle. A cycle with `req_valid` at 0 gives `vic_valid` 0 in the next cycle.
- R3: With each victim, `vic_owner` equals the `req_core` value of the request it answers.
- R4: If any way in the set is invalid (`way_valid` bit 0), the victim is the lowest-numbered invalid way, whether the requester's flag is set or not.
- R5: If all ways are valid and the requester's flag is clear, the victim is the way with the largest age. Age 0 is most recently used and larger values are older. When ages tie, the lowest-numbered way wins.
- R6: If all ways are valid, the requester's flag is set and it owns at least one way, the victim is a way whose owner field equals `req_core`.
- R7: If all ways are valid, the requester's flag is set and it owns no way in the set, the victim is chosen as in R5.
- R8: Random choice comes from a free-running generator that advances every cycle. When the same set, with several ways owned by a flagged requester, is presented again and again, more than one of those ways gets chosen.
- R9: Only the requester's own flag (bit `req_core` of `over_alloc`) changes the choice. Flags of other cores have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Miss request present this cycle |
| req_core | input | CORE_W | Requesting core |
| way_valid | input | NUM_WAYS | Valid bit of each way in the set |
| way_owner | input | NUM_WAYS*CORE_W | Owner field of each way, way 0 in the low bits |
| way_age | input | NUM_WAYS*WAY_W | LRU age of each way, way 0 in the low bits |
| over_alloc | input | NUM_CORES | Over-allocation flag of each core |
| vic_valid | output | 1 | Victim result valid |
| vic_way | output | WAY_W | Chosen way |
| vic_owner | output | CORE_W | Owner value to write into the chosen way |

## Verification
The bench looks for sets that mix empty ways with a flagged requester. A design that tested the flag before validity would throw out an owned line while an empty way was free. Flagged requesters that own exactly one way, or none, are run as well: the first must always get that single way, and a design that did not fall back to LRU in the second would pick a way owned by another core or return nothing useful. It also sets other cores' flags and builds tied ages, which catch designs that index the wrong flag bit or break ties toward the higher way. Repeated identical owned-only requests show whether the random choice is stuck on one way.

// File: rtl/victim_pkg.sv
// Shared types and constants for the victim selector.
// Assumes: nothing beyond IEEE 1800-2017.
package victim_pkg;
    // Which rule produced the victim.
    typedef enum logic [1:0] {
        PICK_FILL = 2'd0,
        PICK_OWN  = 2'd1,
        PICK_LRU  = 2'd2
    } pick_kind_t;

    localparam int          RND_W    = 16;
    localparam logic [15:0] RND_TAPS = 16'hB400;
    localparam logic [15:0] RND_SEED = 16'hACE1;
endpackage

// File: rtl/rnd_gen.sv
// Free-running maximal-length Galois LFSR used as a random source.
// Assumes: the seed is non-zero; it advances on every clock out of reset.
module rnd_gen
    import victim_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    output logic [RND_W-1:0] rnd
);
    logic [RND_W-1:0] state;

    // Shift one step per cycle, applying the taps when the low bit is one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RND_SEED;
        end else begin
            state <= (state >> 1) ^ (state[0] ? RND_TAPS : '0);
        end
    end

    assign rnd = state;

    AST_RND_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);  // R8
endmodule

// File: rtl/lru_pick.sv
// Picks the oldest way by age; ties resolve to the lowest index.
// Assumes: age 0 is most recent, larger values are older.
module lru_pick #(
    parameter int NUM_WAYS = 8,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS*WAY_W-1:0] ages,
    output logic [WAY_W-1:0]          way
);
    // Linear scan keeping the first strictly larger age.
    always_comb begin
        logic [WAY_W-1:0] best_age;
        best_age = ages[WAY_W-1:0];
        way      = '0;
        for (int w = 1; w < NUM_WAYS; w++) begin
            if (ages[w*WAY_W +: WAY_W] > best_age) begin
                best_age = ages[w*WAY_W +: WAY_W];
                way      = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/rot_pick.sv
// Returns the first set bit of a mask found by scanning upward from a start
// index and wrapping around.
// Assumes: start is below NUM_WAYS; way is don't-care when hit is 0.
module rot_pick #(
    parameter int NUM_WAYS = 8,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0] mask,
    input  logic [WAY_W-1:0]    start,
    output logic                hit,
    output logic [WAY_W-1:0]    way
);
    // Circular priority scan beginning at the start index.
    always_comb begin
        int idx;
        hit = 1'b0;
        way = '0;
        for (int k = 0; k < NUM_WAYS; k++) begin
            idx = (int'(start) + k) % NUM_WAYS;
            if (!hit && mask[idx]) begin
                hit = 1'b1;
                way = WAY_W'(idx);
            end
        end
    end
endmodule

// File: rtl/victim_picker.sv
// Victim selector for one set of a shared cache with per-core ownership.
// Order of rules: empty way first, then owned-only random pick for a flagged
// requester that owns something, otherwise LRU. The result is registered.
// Assumes: NUM_CORES is a power of two; ages come from the set's LRU state.
module victim_picker
    import victim_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_WAYS  = 8,
    localparam int CORE_W   = $clog2(NUM_CORES),
    localparam int WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [CORE_W-1:0]          req_core,
    input  logic [NUM_WAYS-1:0]        way_valid,
    input  logic [NUM_WAYS*CORE_W-1:0] way_owner,
    input  logic [NUM_WAYS*WAY_W-1:0]  way_age,
    input  logic [NUM_CORES-1:0]       over_alloc,
    output logic                       vic_valid,
    output logic [WAY_W-1:0]           vic_way,
    output logic [CORE_W-1:0]          vic_owner
);
    logic [RND_W-1:0]    rnd;
    logic [WAY_W-1:0]    rnd_start;
    logic [NUM_WAYS-1:0] own_mask;
    logic                own_hit;
    logic [WAY_W-1:0]    own_way;
    logic [WAY_W-1:0]    lru_way;
    logic                inv_hit;
    logic [WAY_W-1:0]    inv_way;
    pick_kind_t          kind;
    logic [WAY_W-1:0]    next_way;

    pick_kind_t          r_kind;
    logic [NUM_WAYS-1:0] r_own_mask;
    logic [NUM_WAYS-1:0] r_valid_mask;

    rnd_gen u_rnd (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd)
    );

    // Reduce the random word to a starting way.
    assign rnd_start = WAY_W'(rnd % RND_W'(NUM_WAYS));

    // Mark the valid ways held by the requester.
    always_comb begin
        for (int w = 0; w < NUM_WAYS; w++) begin
            own_mask[w] = way_valid[w] && (way_owner[w*CORE_W +: CORE_W] == req_core);
        end
    end

    rot_pick #(.NUM_WAYS(NUM_WAYS)) u_own (
        .mask  (own_mask),
        .start (rnd_start),
        .hit   (own_hit),
        .way   (own_way)
    );

    // The empty way search is the same scan started from way 0.
    rot_pick #(.NUM_WAYS(NUM_WAYS)) u_inv (
        .mask  (~way_valid),
        .start ('0),
        .hit   (inv_hit),
        .way   (inv_way)
    );

    lru_pick #(.NUM_WAYS(NUM_WAYS)) u_lru (
        .ages (way_age),
        .way  (lru_way)
    );

    // Apply the rule order and select the way.
    always_comb begin
        if (inv_hit) begin
            kind     = PICK_FILL;
            next_way = inv_way;
        end else if (over_alloc[req_core] && own_hit) begin
            kind     = PICK_OWN;
            next_way = own_way;
        end else begin
            kind     = PICK_LRU;
            next_way = lru_way;
        end
    end

    // Register the victim one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vic_valid    <= 1'b0;
            vic_way      <= '0;
            vic_owner    <= '0;
            r_kind       <= PICK_LRU;
            r_own_mask   <= '0;
            r_valid_mask <= '0;
        end else begin
            vic_valid <= req_valid;
            if (req_valid) begin
                vic_way      <= next_way;
                vic_owner    <= req_core;
                r_kind       <= kind;
                r_own_mask   <= own_mask;
                r_valid_mask <= way_valid;
            end
        end
    end

    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> vic_valid);  // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !vic_valid);  // R2
    AST_OWNER_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (vic_owner == $past(req_core)));  // R3
    AST_FILL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (vic_valid && r_kind == PICK_FILL) |-> !r_valid_mask[vic_way]);  // R4
    AST_OWN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (vic_valid && r_kind == PICK_OWN) |-> r_own_mask[vic_way]);  // R6
endmodule

// File: tb/test_victim_picker.sv
`timescale 1ns/1ps
module test_victim_picker;
    localparam int NUM_CORES = 4;
    localparam int NUM_WAYS  = 8;
    localparam int CORE_W    = $clog2(NUM_CORES);
    localparam int WAY_W     = $clog2(NUM_WAYS);

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic                       req_valid = 1'b0;
    logic [CORE_W-1:0]          req_core = '0;
    logic [NUM_WAYS-1:0]        way_valid = '0;
    logic [NUM_WAYS*CORE_W-1:0] way_owner;
    logic [NUM_WAYS*WAY_W-1:0]  way_age;
    logic [NUM_CORES-1:0]       over_alloc = '0;
    logic                       vic_valid;
    logic [WAY_W-1:0]           vic_way;
    logic [CORE_W-1:0]          vic_owner;

    int owner_a [NUM_WAYS];
    int age_a   [NUM_WAYS];

    int n_vec  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    victim_picker #(.NUM_CORES(NUM_CORES), .NUM_WAYS(NUM_WAYS)) i_victim_picker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_core(req_core),
        .way_valid(way_valid), .way_owner(way_owner), .way_age(way_age),
        .over_alloc(over_alloc), .vic_valid(vic_valid), .vic_way(vic_way),
        .vic_owner(vic_owner)
    );

    always_comb begin
        for (int w = 0; w < NUM_WAYS; w++) begin
            way_owner[w*CORE_W +: CORE_W] = CORE_W'(owner_a[w]);
            way_age[w*WAY_W +: WAY_W]     = WAY_W'(age_a[w]);
        end
    end

    task automatic fail(input string tag, input int act, input int exp);
        n_fail++;
        $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    endtask

    // Reference model state captured at each rising edge.
    bit       started = 0;
    bit       m_v, m_rst;
    int       m_kind;    // 0 fill, 1 own, 2 lru
    int       m_way, m_core;
    bit [NUM_WAYS-1:0] m_mask;
    string    m_tag;
    bit [NUM_WAYS-1:0] hits;

    always @(posedge clk) begin
        int  best;
        bit  found;
        bit  flag, other;
        started = 1;
        m_rst   = !rst_n;
        m_v     = rst_n && req_valid;
        if (m_v) begin
            m_core = int'(req_core);
            flag   = over_alloc[req_core];
            other  = 0;
            for (int c = 0; c < NUM_CORES; c++) if (c != m_core && over_alloc[c]) other = 1;
            m_mask = '0;
            for (int w = 0; w < NUM_WAYS; w++)
                if (way_valid[w] && owner_a[w] == m_core) m_mask[w] = 1;
            found = 0;
            for (int w = 0; w < NUM_WAYS; w++)
                if (!found && !way_valid[w]) begin found = 1; m_way = w; end
            if (found) begin
                m_kind = 0; m_tag = "R4";
            end else if (flag && m_mask != '0) begin
                m_kind = 1; m_tag = "R6";
            end else begin
                m_kind = 2;
                best = -1;
                for (int w = 0; w < NUM_WAYS; w++)
                    if (age_a[w] > best) begin best = age_a[w]; m_way = w; end
                m_tag = flag ? "R7" : (other ? "R9" : "R5");
            end
        end
    end

    // Compare outputs against the model in the middle of each cycle.
    always @(negedge clk) begin
        if (started) begin
            n_vec++;
            if (vic_valid !== m_v) begin
                fail(m_rst ? "R1" : "R2", int'(vic_valid), int'(m_v));
            end else if (m_v) begin
                if (vic_owner !== CORE_W'(m_core)) fail("R3", int'(vic_owner), m_core);
                if (m_kind == 1) begin
                    if (!m_mask[vic_way]) fail(m_tag, int'(vic_way), -1);
                    hits[vic_way] = 1'b1;
                end else if (int'(vic_way) != m_way) begin
                    fail(m_tag, int'(vic_way), m_way);
                end
            end
        end
    end

    task automatic request(input int core);
        @(negedge clk);
        req_core  = CORE_W'(core);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic set_ages_rot(input int rot);
        for (int w = 0; w < NUM_WAYS; w++) age_a[w] = (w + rot) % NUM_WAYS;
    endtask

    task automatic set_owner_all(input int core);
        for (int w = 0; w < NUM_WAYS; w++) owner_a[w] = core;
    endtask

    bit done = 0;

    initial begin
        #(200000 * 4);
        if (!done) begin
            fail("watchdog", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        set_owner_all(1);
        set_ages_rot(0);
        repeat (5) @(negedge clk);       // R1 checked by the monitor during reset
        rst_n = 1'b1;
        repeat (3) @(negedge clk);       // R2 idle cycles

        // R4: single empty way, flagged requester owning others
        way_valid = 8'hDF; over_alloc = 4'b0010;
        request(1);
        // R4: several empty ways, lowest wins
        way_valid = 8'b0101_0011;
        request(2);
        // R5: all valid, ages rotated
        way_valid = '1; over_alloc = '0;
        for (int r = 0; r < NUM_WAYS; r++) begin set_ages_rot(r); request(r % NUM_CORES); end
        // R5: tied ages pick way 0; partial tie picks lower of the two oldest
        for (int w = 0; w < NUM_WAYS; w++) age_a[w] = 3;
        request(0);
        age_a[2] = 6; age_a[5] = 6;
        request(3);
        // R6: flagged requester owns ways 2 and 6
        set_ages_rot(3);
        set_owner_all(0); owner_a[2] = 3; owner_a[6] = 3;
        over_alloc = 4'b1000;
        for (int i = 0; i < 6; i++) request(3);
        // R6: owns exactly way 3
        set_owner_all(2); owner_a[3] = 1; over_alloc = 4'b0010;
        for (int i = 0; i < 4; i++) request(1);
        // R7: flagged but owns nothing -> LRU
        set_owner_all(2); over_alloc = 4'b0001;
        request(0);
        // R9: other cores flagged, requester clear -> LRU
        over_alloc = 4'b1101; set_owner_all(1);
        request(1);
        // R8: repeated identical owned-only requests spread across ways
        set_owner_all(2); over_alloc = 4'b0100; hits = '0;
        for (int i = 0; i < 40; i++) request(2);
        n_vec++;
        if ($countones(hits) < 2) fail("R8", $countones(hits), 2);
        // Mixed random patterns
        for (int i = 0; i < 400; i++) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                owner_a[w] = $urandom_range(NUM_CORES - 1);
                age_a[w]   = $urandom_range(NUM_WAYS - 1);
            end
            way_valid  = ($urandom_range(3) == 0) ? NUM_WAYS'($urandom) : '1;
            over_alloc = NUM_CORES'($urandom);
            if ($urandom_range(1) == 0) request($urandom_range(NUM_CORES - 1));
            else @(negedge clk);
        end
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule